// File: doc/BRIEF.md
# SDRAM Read Latency Output Pipeline

This block sits on the device side of a synchronous DRAM, between the column data path and the data pins. Each read beat strobe brings in one internally fetched 16-bit word. The block delays that word by the programmed read latency of 2 or 3 clocks and presents it on the data bus, together with one output-enable bit for each byte lane. Two byte-lane mask inputs act on both directions. On reads they switch off a lane's output enable two clocks after they are sampled. On write beats they withhold that lane's write strobe in the same clock.

A burst-stop or precharge event discards any read beat issued in the same clock. This lets the bus fall back to high impedance once the beats already in flight have drained, which takes a delay equal to the latency. Consecutive beats stream out without a gap. The latency setting may change only while no read is in flight.

Top module: `sdr_rd_pipe`

## Requirements
- R1: While reset is held and on the first cycle after it, `dq_oe` is 00, `dq_out` is zero and `wr_be` is 00 when `wr_beat` is low.
- R2: With `cl_sel` = 0 (latency 2), a read beat sampled at rising edge k without `burst_stop` puts its word on `dq_out`, with `dq_oe` set on unmasked lanes, for sampling at edge k+2.
- R3: With `cl_sel` = 1 (latency 3), the same word is presented for sampling at edge k+3.
- R4: A mask bit sampled high at edge m clears that lane's `dq_oe` for sampling at edge m+2, at either latency. `dqm[1]` covers bits 15:8 and `dqm[0]` covers bits 7:0.
- R5: `wr_be[i]` equals `wr_beat` AND NOT `dqm[i]` within the same cycle, with no register in between.
- R6: A read beat sampled together with `burst_stop` is discarded. If no further beat follows, `dq_oe` is 00 at edge p+CL after a stop at edge p.
- R7: Read beats on consecutive edges give `dq_oe` high on consecutive sampling edges with no gap. `dq_oe` falls at the first sampling edge that has no beat behind it.
- R8: The byte lanes keep their position: `dq_out[15:8]` carries bits 15:8 of the beat word and `dq_out[7:0]` carries bits 7:0, whatever the mask on the other lane.
- R9: Write beats have no effect on `dq_oe` or `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled and every output is launched on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_sel | input | 1 | Latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| rd_beat | input | 1 | Read beat strobe; `rd_data` is valid |
| rd_data | input | 16 | Word fetched for this read beat |
| burst_stop | input | 1 | Burst-stop or precharge event ending the read |
| wr_beat | input | 1 | Write beat strobe |
| dqm | input | 2 | Byte-lane masks; bit 1 covers bits 15:8 and bit 0 covers bits 7:0 |
| dq_out | output | 16 | Value driven on the data bus |
| dq_oe | output | 2 | Output enable for each byte lane |
| wr_be | output | 2 | Write strobe for each byte lane for the current write beat |

## Verification
Every result has a fixed delay. Read data and its output enable are due CL edges after the beat. A read mask acts 2 edges after it is sampled. Write strobes are due in the same cycle. The bench keeps a history of everything it drove, indexed by edge number. At each falling edge it works out from that history which beat and which mask govern the outputs the last rising edge produced, and compares against them. Write strobes are checked 1 ns after the inputs change, before the next rising edge. The latency is switched only after enough idle cycles to empty the pipeline.

// File: rtl/sdr_rd_pipe_pkg.sv
package sdr_rd_pipe_pkg;
   localparam int DEF_DATA_W  = 16;
   localparam int DEF_LANES   = 2;
   localparam int DEF_DEPTH   = 3;
   localparam int DEF_MIN_LAT = 2;
   localparam int RD_MASK_DLY = 2;

   function automatic int sel_width(input int depth, input int min_lat);
      return (depth - min_lat > 0) ? $clog2(depth - min_lat + 1) : 1;
   endfunction
endpackage

// File: rtl/rdp_stage_chain.sv
module rdp_stage_chain #(
   parameter int W     = 16,
   parameter int DEPTH = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_vld,
   input  logic [W-1:0]              in_dat,
   output logic [DEPTH-1:0]          vld,
   output logic [DEPTH-1:0][W-1:0]   dat
);
   initial begin
      assert (DEPTH >= 1) else $fatal(1, "rdp_stage_chain: DEPTH must be >= 1");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld[g] <= 1'b0;
               dat[g] <= '0;
            end else begin
               vld[g] <= in_vld;
               dat[g] <= in_dat;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld[g] <= 1'b0;
               dat[g] <= '0;
            end else begin
               vld[g] <= vld[g-1];
               dat[g] <= dat[g-1];
            end
         end
      end
   end
endmodule

// File: rtl/rdp_tap_sel.sv
module rdp_tap_sel #(
   parameter int W       = 16,
   parameter int DEPTH   = 3,
   parameter int MIN_LAT = 2,
   parameter int SEL_W   = 1
) (
   input  logic [SEL_W-1:0]          sel,
   input  logic [DEPTH-1:0]          vld,
   input  logic [DEPTH-1:0][W-1:0]   dat,
   output logic                      tap_vld,
   output logic [W-1:0]              tap_dat
);
   localparam int SPAN = DEPTH - MIN_LAT + 1;

   initial begin
      assert (SPAN >= 1) else $fatal(1, "rdp_tap_sel: DEPTH must be >= MIN_LAT");
   end

   if (SPAN == 1) begin : g_fixed
      assign tap_vld = vld[DEPTH-1];
      assign tap_dat = dat[DEPTH-1];
   end else begin : g_var
      always_comb begin
         int idx;
         idx = MIN_LAT - 1 + int'(sel);
         if (idx > DEPTH - 1) idx = DEPTH - 1;
         tap_vld = vld[idx];
         tap_dat = dat[idx];
      end
   end
endmodule

// File: rtl/rdp_mask_delay.sv
module rdp_mask_delay #(
   parameter int LANES = 2,
   parameter int DLY   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] mask_in,
   output logic [LANES-1:0] mask_out
);
   logic [DLY-1:0][LANES-1:0] pipe;

   initial begin
      assert (DLY >= 1) else $fatal(1, "rdp_mask_delay: DLY must be >= 1");
   end

   for (genvar g = 0; g < DLY; g++) begin : g_tap
      always_ff @(posedge clk) begin
         if (!rst_n)      pipe[g] <= '0;
         else if (g == 0) pipe[g] <= mask_in;
         else             pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
   end

   assign mask_out = pipe[DLY-1];
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
   parameter int DATA_W  = sdr_rd_pipe_pkg::DEF_DATA_W,
   parameter int LANES   = sdr_rd_pipe_pkg::DEF_LANES,
   parameter int DEPTH   = sdr_rd_pipe_pkg::DEF_DEPTH,
   parameter int MIN_LAT = sdr_rd_pipe_pkg::DEF_MIN_LAT,
   parameter int SEL_W   = sdr_rd_pipe_pkg::sel_width(DEPTH, MIN_LAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  cl_sel,
   input  logic              rd_beat,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              burst_stop,
   input  logic              wr_beat,
   input  logic [LANES-1:0]  dqm,
   output logic [DATA_W-1:0] dq_out,
   output logic [LANES-1:0]  dq_oe,
   output logic [LANES-1:0]  wr_be
);
   localparam int LANE_W = DATA_W / LANES;

   initial begin
      assert (DATA_W % LANES == 0) else $fatal(1, "sdr_rd_pipe: DATA_W not a multiple of LANES");
      assert (MIN_LAT >= 1)        else $fatal(1, "sdr_rd_pipe: MIN_LAT must be >= 1");
      assert (DEPTH >= MIN_LAT)    else $fatal(1, "sdr_rd_pipe: DEPTH below MIN_LAT");
      assert (LANE_W >= 1)         else $fatal(1, "sdr_rd_pipe: empty lane");
   end

   logic                       beat_kept;
   logic [DEPTH-1:0]           st_vld;
   logic [DEPTH-1:0][DATA_W-1:0] st_dat;
   logic                       tap_vld;
   logic [DATA_W-1:0]          tap_dat;
   logic [LANES-1:0]           rd_mask_d;

   // A beat coinciding with a stop/precharge never enters the pipeline
   assign beat_kept = rd_beat & ~burst_stop;

   rdp_stage_chain #(.W(DATA_W), .DEPTH(DEPTH)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vld (beat_kept),
      .in_dat (rd_data),
      .vld    (st_vld),
      .dat    (st_dat)
   );

   rdp_tap_sel #(.W(DATA_W), .DEPTH(DEPTH), .MIN_LAT(MIN_LAT), .SEL_W(SEL_W)) u_tap (
      .sel     (cl_sel),
      .vld     (st_vld),
      .dat     (st_dat),
      .tap_vld (tap_vld),
      .tap_dat (tap_dat)
   );

   rdp_mask_delay #(.LANES(LANES), .DLY(sdr_rd_pipe_pkg::RD_MASK_DLY)) u_rmask (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_in  (dqm),
      .mask_out (rd_mask_d)
   );

   assign dq_out = tap_vld ? tap_dat : '0;
   assign dq_oe  = {LANES{tap_vld}} & ~rd_mask_d;
   // Write path: mask acts on the beat of the same clock
   assign wr_be  = {LANES{wr_beat}} & ~dqm;

   for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      AST_RD_MASK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
         dqm[g] |=> ##1 !dq_oe[g]); // R4
   end

   if (MIN_LAT == 2 && DEPTH >= 3) begin : g_lat_chk
      AST_CL2_DATA: assert property (@(posedge clk) disable iff (!rst_n)
         (cl_sel == SEL_W'(0) && rd_beat && !burst_stop) |=> ##1 (dq_out == $past(rd_data, 2))); // R2
      AST_CL3_DATA: assert property (@(posedge clk) disable iff (!rst_n)
         (cl_sel == SEL_W'(1) && rd_beat && !burst_stop) |=> ##2 (dq_out == $past(rd_data, 3))); // R3
      AST_CL2_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         (cl_sel == SEL_W'(0) && dq_oe != '0) |-> $past(rd_beat && !burst_stop, 2)); // R6
      AST_CL3_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         (cl_sel == SEL_W'(1) && dq_oe != '0) |-> $past(rd_beat && !burst_stop, 3)); // R6
   end
endmodule

// File: tb/sdr_rd_pipe_tb.sv
`timescale 1ns/1ps
module sdr_rd_pipe_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [0:0]  cl_sel = 1'b0;
   logic        rd_beat = 1'b0;
   logic [15:0] rd_data = '0;
   logic        burst_stop = 1'b0;
   logic        wr_beat = 1'b0;
   logic [1:0]  dqm = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;
   logic [1:0]  wr_be;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int cl = 2;
   int cnt = 0;
   logic        hb [0:8191];
   logic        hs [0:8191];
   logic [1:0]  hm [0:8191];
   logic [15:0] hd [0:8191];

   always #4 clk = ~clk;

   sdr_rd_pipe u_dut (
      .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel), .rd_beat(rd_beat),
      .rd_data(rd_data), .burst_stop(burst_stop), .wr_beat(wr_beat),
      .dqm(dqm), .dq_out(dq_out), .dq_oe(dq_oe), .wr_be(wr_be)
   );

   function automatic logic exp_valid(input int last);
      int idx = last - (cl - 1);
      if (idx < 0) return 1'b0;
      return hb[idx] && !hs[idx];
   endfunction

   function automatic logic exp_masked(input int last, input int lane);
      if (last - 1 < 0) return 1'b0;
      return hm[last-1][lane];
   endfunction

   task automatic check_regs(input string tag);
      int last = cnt - 1;
      int idx = last - (cl - 1);
      for (int ln = 0; ln < 2; ln++) begin
         logic on;
         string t;
         on = exp_valid(last) && !exp_masked(last, ln);
         t = exp_masked(last, ln) ? "R4" : tag;
         checks++;
         if (dq_oe[ln] !== on) begin
            errors++;
            $display("FAIL %s: lane %0d oe actual %b expected %b (edge %0d)", t, ln, dq_oe[ln], on, last);
         end
         if (on) begin
            checks++;
            if (dq_out[ln*8 +: 8] !== hd[idx][ln*8 +: 8]) begin
               errors++;
               $display("FAIL %s: lane %0d data actual %h expected %h (edge %0d)",
                        tag, ln, dq_out[ln*8 +: 8], hd[idx][ln*8 +: 8], last);
            end
         end
      end
   endtask

   task automatic step(input string tag, input logic b, input logic s, input logic [15:0] d,
                       input logic [1:0] m, input logic w);
      logic [1:0] ew;
      @(negedge clk);
      check_regs(tag);
      rd_beat = b; burst_stop = s; rd_data = d; dqm = m; wr_beat = w;
      #1;
      ew = {2{w}} & ~m;
      checks++;
      if (wr_be !== ew) begin
         errors++;
         $display("FAIL R5: wr_be actual %b expected %b", wr_be, ew);
      end
      hb[cnt] = b; hs[cnt] = s; hd[cnt] = d; hm[cnt] = m;
      cnt++;
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 16'h0, 2'b00, 1'b0);
   endtask

   task automatic rnd(input string tag, input int n, input int pb, input int ps, input int pm, input int pw);
      for (int i = 0; i < n; i++) begin
         logic [1:0] m;
         m[0] = ($urandom % 100) < pm;
         m[1] = ($urandom % 100) < pm;
         step(tag, ($urandom % 100) < pb, ($urandom % 100) < ps, 16'($urandom), m,
              ($urandom % 100) < pw);
      end
   endtask

   task automatic set_cl(input int n);
      idle("R6", 5);
      cl = n;
      cl_sel = (n == 3) ? 1'b1 : 1'b0;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd1357);
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (dq_oe !== 2'b00 || dq_out !== 16'h0 || wr_be !== 2'b00) begin
         errors++;
         $display("FAIL R1: oe/out/wr_be actual %b/%h/%b expected 00/0000/00", dq_oe, dq_out, wr_be);
      end
      rst_n = 1'b1;
      step("R1", 1'b0, 1'b0, 16'h0, 2'b00, 1'b0);

      // CL2 directed
      step("R2", 1'b1, 1'b0, 16'h1234, 2'b00, 1'b0);
      idle("R2", 4);
      for (int i = 0; i < 8; i++) step("R7", 1'b1, 1'b0, 16'(16'h3000 + i), 2'b00, 1'b0);
      idle("R7", 4);
      step("R6", 1'b1, 1'b0, 16'h0A0A, 2'b00, 1'b0);
      step("R6", 1'b1, 1'b0, 16'h0B0B, 2'b00, 1'b0);
      step("R6", 1'b1, 1'b1, 16'h0C0C, 2'b00, 1'b0);
      idle("R6", 4);
      rnd("R2", 500, 60, 8, 20, 20);

      set_cl(3);
      step("R3", 1'b1, 1'b0, 16'hBEEF, 2'b00, 1'b0);
      idle("R3", 5);
      for (int i = 0; i < 8; i++) step("R7", 1'b1, 1'b0, 16'(16'h7100 + i), 2'b00, 1'b0);
      idle("R7", 5);
      step("R6", 1'b1, 1'b0, 16'h5151, 2'b00, 1'b0);
      step("R6", 1'b1, 1'b1, 16'h5252, 2'b00, 1'b0);
      idle("R6", 5);
      rnd("R3", 500, 60, 8, 20, 20);

      // R4: mask toggling over a long burst at latency 3
      for (int i = 0; i < 12; i++) step("R4", 1'b1, 1'b0, 16'(16'hC000 + i), 2'(i % 4), 1'b0);
      idle("R4", 5);
      // R8: distinct lane bytes, one lane masked at a time
      step("R8", 1'b1, 1'b0, 16'hA55A, 2'b00, 1'b0);
      step("R8", 1'b1, 1'b0, 16'h12EF, 2'b10, 1'b0);
      step("R8", 1'b1, 1'b0, 16'hFE21, 2'b01, 1'b0);
      idle("R8", 5);
      set_cl(2);
      for (int i = 0; i < 12; i++) step("R4", 1'b1, 1'b0, 16'(16'hD000 + i), 2'(3 - (i % 4)), 1'b0);
      idle("R4", 4);
      // R5: every mask with write beats, no reads
      for (int i = 0; i < 8; i++) step("R5", 1'b0, 1'b0, 16'h0, 2'(i), 1'(i >> 2));
      // R9: heavy write traffic interleaved with reads
      rnd("R9", 300, 40, 5, 30, 90);
      set_cl(3);
      rnd("R9", 300, 40, 5, 30, 90);
      idle("R9", 5);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule